// File: doc/BRIEF.md
# Receive Descriptor Chain Manager

This block prepares a linear chain of receive descriptors in a small on-chip descriptor store and then follows a consumer as it steps along that chain. A start command carries a buffer base address, a conversions-per-frame count and a descriptor count. The byte size of each descriptor's buffer is that count multiplied by a fixed number of bytes per conversion. Every descriptor is filled in during the cycle the start is accepted. Each descriptor gets its buffer size, a zero length, a clear end-of-frame flag, an owner bit handed to the mover, its buffer pointer and a pointer to the next descriptor.

The consumer issues queries and supplies the end-of-frame descriptor address that the data mover last reported. A cursor begins at a dummy head that sits ahead of descriptor 0. Each query gets one of three answers. It reports NULL when nothing follows the cursor, and WAITING when the cursor sits at the reported end-of-frame descriptor. In all other cases the cursor moves forward and the answer is VALID, together with the index and address of the descriptor just reached. A read port returns the fields of any descriptor so that the consumer can inspect the data it has been handed.

Top module: `rxd_chain_mgr`

## Requirements
- R1: An accepted start writes size = eof_num × BYTES_PER_CONV, length 0, end-of-frame flag 0 and owner bit 1 into each descriptor n below start_count.
- R2: The buffer pointer of descriptor n is start_base + n × size. Its next pointer is DESC_BASE + 12 × (n+1), except for the last descriptor, where it is 0 (null). The descriptor at index n lives at address DESC_BASE + 12 × n.
- R3: A start is rejected, and start_err is 1 in the following cycle, when start_base[1:0] ≠ 0, when size is not a multiple of 4, when size is 0 or above 4095, or when start_count is 0 or above MAX_DESC. A rejected start leaves the descriptors and the cursor as they were. An accepted start gives start_err = 0.
- R4: After an accepted start the cursor is at the dummy head (address HEAD_ADDR), and the head's next pointer is descriptor 0. Before any accepted start after reset, the head's next pointer is null.
- R5: A query (q_valid with no start in that cycle) produces exactly one response, with resp_valid = 1 in the following cycle. The status codes are 0 = VALID, 1 = WAITING and 2 = NULL. No response appears without a query.
- R6: When the cursor's next pointer is null, the status is NULL, the cursor stays where it is, and resp_addr is the cursor address. This check takes precedence over the WAITING check.
- R7: When the cursor address equals eof_addr (and its next pointer is not null), the status is WAITING, the cursor stays where it is, and resp_addr is the cursor address.
- R8: In every other case the cursor moves to its next descriptor, and the response is VALID with resp_idx and resp_addr of that descriptor.
- R9: When a start and a query arrive in the same cycle, the start is processed and the query is dropped without a response.
- R10: The read port returns all fields of descriptor rd_idx in the cycle after rd_idx is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Start command strobe |
| start_base | input | 32 | Buffer base address |
| start_eof_num | input | EOF_NUM_W | Conversions per end-of-frame |
| start_count | input | CNT_W | Number of descriptors |
| start_err | output | 1 | Start rejected (one cycle after the start) |
| q_valid | input | 1 | Consumer query strobe |
| eof_addr | input | 32 | End-of-frame descriptor address reported by the mover |
| resp_valid | output | 1 | Query response valid |
| resp_status | output | 2 | 0 VALID, 1 WAITING, 2 NULL |
| resp_idx | output | IDX_W | Index of the descriptor reached (VALID) |
| resp_addr | output | 32 | Address of the descriptor reached, or of the cursor |
| rd_idx | input | IDX_W | Descriptor read index |
| rd_size | output | 12 | Size field |
| rd_length | output | 12 | Length field |
| rd_eof | output | 1 | End-of-frame flag |
| rd_owner | output | 1 | Owner bit |
| rd_buf | output | 32 | Buffer pointer |
| rd_next | output | 32 | Next pointer |

## Verification
Each result becomes visible exactly one register stage after the edge that captures its stimulus. This applies to start_err after a start, to the response after a query, and to the read fields after a read index. The bench drives its inputs on the falling edge, and the result is therefore sampled on the next falling edge. For every query the driver pushes an expected response, which it computes from its own cursor model. The monitor pops and compares an entry on each falling edge where resp_valid is high, flags any response that arrives with nothing expected, and finally checks that no expected response is left unanswered.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    localparam int ADDR_W      = 32;
    localparam int SIZE_W      = 12;
    localparam int SIZE_MAX    = (1 << SIZE_W) - 1;
    localparam int DESC_STRIDE = 12;

    typedef enum logic [1:0] {
        ST_VALID   = 2'd0,
        ST_WAITING = 2'd1,
        ST_NULL    = 2'd2
    } rxd_status_e;

    typedef struct packed {
        logic [SIZE_W-1:0] size;
        logic [SIZE_W-1:0] length;
        logic              eof;
        logic              owner;
        logic [ADDR_W-1:0] buf_ptr;
        logic [ADDR_W-1:0] next_ptr;
    } rxd_desc_t;

    typedef struct packed {
        logic              valid;
        rxd_status_e       status;
        logic [ADDR_W-1:0] addr;
    } rxd_resp_t;

    function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] base,
                                                     input logic [ADDR_W-1:0] idx);
        return base + idx * ADDR_W'(DESC_STRIDE);
    endfunction

endpackage

// File: rtl/rxd_cfg_check.sv
module rxd_cfg_check
    import rxd_pkg::*;
#(
    parameter int MAX_DESC       = 16,
    parameter int BYTES_PER_CONV = 2,
    parameter int EOF_NUM_W      = 12,
    parameter int CNT_W          = 5
) (
    input  logic [ADDR_W-1:0]    base,
    input  logic [EOF_NUM_W-1:0] eof_num,
    input  logic [CNT_W-1:0]     count,
    output logic                 ok,
    output logic [SIZE_W-1:0]    size
);
    localparam int PROD_W = EOF_NUM_W + 8;
    localparam bit POW2   = (BYTES_PER_CONV & (BYTES_PER_CONV - 1)) == 0;

    logic [PROD_W-1:0] prod;

    generate
        if (POW2) begin : g_shift
            assign prod = PROD_W'(eof_num) << $clog2(BYTES_PER_CONV);
        end else begin : g_mult
            assign prod = PROD_W'(eof_num) * PROD_W'(BYTES_PER_CONV);
        end
    endgenerate

    always_comb begin
        ok = (base[1:0] == 2'b00)
          && (prod[1:0] == 2'b00)
          && (prod != '0)
          && (prod <= PROD_W'(SIZE_MAX))
          && (count != '0)
          && (count <= CNT_W'(MAX_DESC));
        size = prod[SIZE_W-1:0];
    end

endmodule

// File: rtl/rxd_desc_store.sv
module rxd_desc_store
    import rxd_pkg::*;
#(
    parameter int                MAX_DESC  = 16,
    parameter int                IDX_W     = 4,
    parameter int                CNT_W     = 5,
    parameter logic [ADDR_W-1:0] DESC_BASE = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_en,
    input  logic [ADDR_W-1:0] init_base,
    input  logic [SIZE_W-1:0] init_size,
    input  logic [CNT_W-1:0]  init_count,
    input  logic [IDX_W-1:0]  rd_idx,
    output rxd_desc_t         rd_desc,
    input  logic [IDX_W-1:0]  cur_idx,
    output logic [ADDR_W-1:0] cur_next
);
    rxd_desc_t slots [MAX_DESC];

    generate
        for (genvar g = 0; g < MAX_DESC; g++) begin : g_slot
            rxd_desc_t slot_q;
            logic      in_chain;
            logic      is_last;

            assign in_chain = ADDR_W'(g) < ADDR_W'(init_count);
            assign is_last  = ADDR_W'(g + 1) == ADDR_W'(init_count);

            always_ff @(posedge clk) begin
                if (rst) begin
                    slot_q <= '0;
                end else if (init_en && in_chain) begin
                    slot_q.size     <= init_size;
                    slot_q.length   <= '0;
                    slot_q.eof      <= 1'b0;
                    slot_q.owner    <= 1'b1;
                    slot_q.buf_ptr  <= init_base + ADDR_W'(g) * ADDR_W'(init_size);
                    slot_q.next_ptr <= is_last ? '0 : slot_addr(DESC_BASE, ADDR_W'(g + 1));
                end
            end

            assign slots[g] = slot_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) rd_desc <= '0;
        else     rd_desc <= slots[rd_idx];
    end

    assign cur_next = slots[cur_idx].next_ptr;

endmodule

// File: rtl/rxd_cursor.sv
module rxd_cursor
    import rxd_pkg::*;
#(
    parameter int                IDX_W     = 4,
    parameter logic [ADDR_W-1:0] DESC_BASE = 32'h0000_1000,
    parameter logic [ADDR_W-1:0] HEAD_ADDR = 32'h0000_0FF4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              query,
    input  logic [ADDR_W-1:0] eof_addr,
    input  logic [ADDR_W-1:0] slot_next,
    output logic [IDX_W-1:0]  cur_idx,
    output rxd_resp_t         resp,
    output logic [IDX_W-1:0]  resp_idx
);
    logic              at_head;
    logic              built;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] nxt_ptr;
    logic [IDX_W-1:0]  adv_idx;

    always_comb begin
        cur_addr = at_head ? HEAD_ADDR : slot_addr(DESC_BASE, ADDR_W'(cur_idx));
        nxt_ptr  = at_head ? (built ? DESC_BASE : '0) : slot_next;
        adv_idx  = at_head ? '0 : cur_idx + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            at_head  <= 1'b1;
            built    <= 1'b0;
            cur_idx  <= '0;
            resp     <= '{valid: 1'b0, status: ST_NULL, addr: '0};
            resp_idx <= '0;
        end else begin
            resp.valid <= 1'b0;
            if (restart) begin
                at_head <= 1'b1;
                built   <= 1'b1;
                cur_idx <= '0;
            end else if (query) begin
                resp.valid <= 1'b1;
                if (nxt_ptr == '0) begin
                    resp.status <= ST_NULL;
                    resp.addr   <= cur_addr;
                    resp_idx    <= cur_idx;
                end else if (cur_addr == eof_addr) begin
                    resp.status <= ST_WAITING;
                    resp.addr   <= cur_addr;
                    resp_idx    <= cur_idx;
                end else begin
                    resp.status <= ST_VALID;
                    resp.addr   <= slot_addr(DESC_BASE, ADDR_W'(adv_idx));
                    resp_idx    <= adv_idx;
                    at_head     <= 1'b0;
                    cur_idx     <= adv_idx;
                end
            end
        end
    end

endmodule

// File: rtl/rxd_chain_mgr.sv
module rxd_chain_mgr
    import rxd_pkg::*;
#(
    parameter int          MAX_DESC       = 16,
    parameter int          BYTES_PER_CONV = 2,
    parameter int          EOF_NUM_W      = 12,
    parameter logic [31:0] DESC_BASE      = 32'h0000_1000,
    parameter logic [31:0] HEAD_ADDR      = 32'h0000_0FF4,
    localparam int         IDX_W          = $clog2(MAX_DESC),
    localparam int         CNT_W          = $clog2(MAX_DESC + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_valid,
    input  logic [31:0]          start_base,
    input  logic [EOF_NUM_W-1:0] start_eof_num,
    input  logic [CNT_W-1:0]     start_count,
    output logic                 start_err,
    input  logic                 q_valid,
    input  logic [31:0]          eof_addr,
    output logic                 resp_valid,
    output logic [1:0]           resp_status,
    output logic [IDX_W-1:0]     resp_idx,
    output logic [31:0]          resp_addr,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [11:0]          rd_size,
    output logic [11:0]          rd_length,
    output logic                 rd_eof,
    output logic                 rd_owner,
    output logic [31:0]          rd_buf,
    output logic [31:0]          rd_next
);
    logic              cfg_ok;
    logic [SIZE_W-1:0] cfg_size;
    logic              start_take;
    logic              query_take;
    logic [IDX_W-1:0]  cur_idx;
    logic [ADDR_W-1:0] cur_next;
    rxd_desc_t         rd_desc;
    rxd_resp_t         resp;

    rxd_cfg_check #(
        .MAX_DESC      (MAX_DESC),
        .BYTES_PER_CONV(BYTES_PER_CONV),
        .EOF_NUM_W     (EOF_NUM_W),
        .CNT_W         (CNT_W)
    ) u_cfg (
        .base   (start_base),
        .eof_num(start_eof_num),
        .count  (start_count),
        .ok     (cfg_ok),
        .size   (cfg_size)
    );

    assign start_take = start_valid && cfg_ok;
    assign query_take = q_valid && !start_valid;

    always_ff @(posedge clk) begin
        if (rst) start_err <= 1'b0;
        else     start_err <= start_valid && !cfg_ok;
    end

    rxd_desc_store #(
        .MAX_DESC (MAX_DESC),
        .IDX_W    (IDX_W),
        .CNT_W    (CNT_W),
        .DESC_BASE(DESC_BASE)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .init_en   (start_take),
        .init_base (start_base),
        .init_size (cfg_size),
        .init_count(start_count),
        .rd_idx    (rd_idx),
        .rd_desc   (rd_desc),
        .cur_idx   (cur_idx),
        .cur_next  (cur_next)
    );

    rxd_cursor #(
        .IDX_W    (IDX_W),
        .DESC_BASE(DESC_BASE),
        .HEAD_ADDR(HEAD_ADDR)
    ) u_cursor (
        .clk      (clk),
        .rst      (rst),
        .restart  (start_take),
        .query    (query_take),
        .eof_addr (eof_addr),
        .slot_next(cur_next),
        .cur_idx  (cur_idx),
        .resp     (resp),
        .resp_idx (resp_idx)
    );

    assign resp_valid  = resp.valid;
    assign resp_status = resp.status;
    assign resp_addr   = resp.addr;
    assign rd_size     = rd_desc.size;
    assign rd_length   = rd_desc.length;
    assign rd_eof      = rd_desc.eof;
    assign rd_owner    = rd_desc.owner;
    assign rd_buf      = rd_desc.buf_ptr;
    assign rd_next     = rd_desc.next_ptr;

endmodule

// File: rtl/rxd_chain_mgr_chk.sv
module rxd_chain_mgr_chk #(
    parameter logic [31:0] HEAD_ADDR = 32'h0000_0FF4
) (
    input logic        clk,
    input logic        rst,
    input logic        start_valid,
    input logic [31:0] start_base,
    input logic        start_err,
    input logic        q_valid,
    input logic [31:0] eof_addr,
    input logic        resp_valid,
    input logic [1:0]  resp_status,
    input logic [31:0] resp_addr
);
    // R3: a misaligned base is always rejected
    a_r3_misaligned_rejected: assert property (@(posedge clk) disable iff (rst)
        (start_valid && start_base[1:0] != 2'b00) |=> start_err);

    // R5: a query without a start is answered in the next cycle
    a_r5_query_answered: assert property (@(posedge clk) disable iff (rst)
        (q_valid && !start_valid) |=> resp_valid);

    // R5: no response without a query
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !q_valid |=> !resp_valid);

    // R5: only the three defined status codes appear
    a_r5_status_legal: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> resp_status != 2'd3);

    // R7: WAITING only when the cursor matches the reported end-of-frame address
    a_r7_wait_matches_eof: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_status == 2'd1) |-> resp_addr == $past(eof_addr));

    // R8: a VALID response never names the dummy head
    a_r8_valid_not_head: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_status == 2'd0) |-> resp_addr != HEAD_ADDR);

    // R9: a start suppresses any query of the same cycle
    a_r9_start_wins: assert property (@(posedge clk) disable iff (rst)
        start_valid |=> !resp_valid);

endmodule

bind rxd_chain_mgr rxd_chain_mgr_chk #(.HEAD_ADDR(HEAD_ADDR)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_valid(start_valid),
    .start_base (start_base),
    .start_err  (start_err),
    .q_valid    (q_valid),
    .eof_addr   (eof_addr),
    .resp_valid (resp_valid),
    .resp_status(resp_status),
    .resp_addr  (resp_addr)
);

// File: tb/rxd_chain_mgr_bench.sv
`timescale 1ns/1ps
module rxd_chain_mgr_bench;

    localparam int          MAX_DESC  = 16;
    localparam int          BPC       = 2;
    localparam int          EOF_NUM_W = 12;
    localparam logic [31:0] DB        = 32'h0000_1000;
    localparam logic [31:0] HEAD      = 32'h0000_0FF4;
    localparam int          IDX_W     = 4;
    localparam int          CNT_W     = 5;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 start_valid = 1'b0;
    logic [31:0]          start_base = '0;
    logic [EOF_NUM_W-1:0] start_eof_num = '0;
    logic [CNT_W-1:0]     start_count = '0;
    logic                 start_err;
    logic                 q_valid = 1'b0;
    logic [31:0]          eof_addr = '0;
    logic                 resp_valid;
    logic [1:0]           resp_status;
    logic [IDX_W-1:0]     resp_idx;
    logic [31:0]          resp_addr;
    logic [IDX_W-1:0]     rd_idx = '0;
    logic [11:0]          rd_size;
    logic [11:0]          rd_length;
    logic                 rd_eof;
    logic                 rd_owner;
    logic [31:0]          rd_buf;
    logic [31:0]          rd_next;

    always #2.5 clk = ~clk;

    rxd_chain_mgr u_rxd_chain_mgr (
        .clk(clk), .rst(rst),
        .start_valid(start_valid), .start_base(start_base),
        .start_eof_num(start_eof_num), .start_count(start_count),
        .start_err(start_err),
        .q_valid(q_valid), .eof_addr(eof_addr),
        .resp_valid(resp_valid), .resp_status(resp_status),
        .resp_idx(resp_idx), .resp_addr(resp_addr),
        .rd_idx(rd_idx), .rd_size(rd_size), .rd_length(rd_length),
        .rd_eof(rd_eof), .rd_owner(rd_owner), .rd_buf(rd_buf), .rd_next(rd_next)
    );

    typedef struct {
        int    status;
        int    idx;
        int    addr;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;

    // bench cursor model: -1 is the dummy head
    int m_cur   = -1;
    int m_built = 0;
    int m_cnt   = 0;
    int m_base  = 0;
    int m_size  = 0;

    function automatic int slot(input int n);
        return int'(DB) + 12 * n;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: pops one expected item per response
    always @(negedge clk) begin
        if (!rst && resp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5", "unexpected response", int'(resp_status), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(int'(resp_status) == e.status, e.req, "status", int'(resp_status), e.status);
                chk(int'(resp_addr) == e.addr, e.req, "addr", int'(resp_addr), e.addr);
                if (e.status == 0)
                    chk(int'(resp_idx) == e.idx, e.req, "idx", int'(resp_idx), e.idx);
            end
        end
    end

    task automatic do_start(input int base, input int eofn, input int cnt,
                            input bit exp_err, input string req);
        @(negedge clk);
        start_valid   = 1'b1;
        start_base    = base;
        start_eof_num = EOF_NUM_W'(eofn);
        start_count   = CNT_W'(cnt);
        @(negedge clk);
        start_valid = 1'b0;
        chk(start_err == exp_err, req, "start_err", int'(start_err), int'(exp_err));
        if (!exp_err) begin
            m_cur = -1; m_built = 1; m_cnt = cnt; m_base = base; m_size = eofn * BPC;
        end
    endtask

    task automatic do_query(input int eof, input string req);
        exp_t e;
        int   cur_a;
        int   nxt;
        cur_a = (m_cur < 0) ? int'(HEAD) : slot(m_cur);
        if (m_cur < 0) nxt = m_built ? int'(DB) : 0;
        else           nxt = (m_cur == m_cnt - 1) ? 0 : slot(m_cur + 1);
        e.req = req;
        e.idx = 0;
        if (nxt == 0) begin
            e.status = 2; e.addr = cur_a;
        end else if (cur_a == eof) begin
            e.status = 1; e.addr = cur_a;
        end else begin
            m_cur = m_cur + 1;
            e.status = 0; e.addr = slot(m_cur); e.idx = m_cur;
        end
        @(negedge clk);
        exp_q.push_back(e);
        q_valid  = 1'b1;
        eof_addr = eof;
        @(negedge clk);
        q_valid = 1'b0;
    endtask

    task automatic check_desc(input int n, input string req);
        @(negedge clk);
        rd_idx = IDX_W'(n);
        @(negedge clk);
        chk(int'(rd_size) == m_size, "R1", "size", int'(rd_size), m_size);
        chk(rd_length == 12'd0 && rd_eof == 1'b0 && rd_owner == 1'b1, "R1",
            "len/eof/owner", {rd_length, rd_eof, rd_owner}, 1);
        chk(int'(rd_buf) == m_base + n * m_size, "R2", "buf", int'(rd_buf), m_base + n * m_size);
        chk(int'(rd_next) == ((n == m_cnt - 1) ? 0 : slot(n + 1)), req, "next",
            int'(rd_next), (n == m_cnt - 1) ? 0 : slot(n + 1));
    endtask

    initial begin
        #400000;
        chk(1'b0, "watchdog", "timeout", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(resp_valid == 1'b0, "R5", "reset resp_valid", int'(resp_valid), 0);
        chk(start_err == 1'b0, "R3", "reset start_err", int'(start_err), 0);

        // R4: before any chain, head's next is null -> NULL
        do_query(0, "R4");

        // R1 R2: build four descriptors of 16 bytes
        do_start(32'h2000, 8, 4, 1'b0, "R3");
        for (int n = 0; n < 4; n++) check_desc(n, "R2");

        // R8 walk, then R6 at the tail
        for (int n = 0; n < 4; n++) do_query(0, "R8");
        do_query(0, "R6");
        do_query(slot(3), "R6");   // NULL beats WAITING

        // R7 waiting at head and at a descriptor
        do_start(32'h4000, 4, 3, 1'b0, "R3");
        do_query(int'(HEAD), "R7");
        do_query(slot(0), "R8");
        do_query(slot(0), "R7");
        do_query(slot(2), "R8");
        do_query(slot(2), "R8");
        do_query(slot(2), "R6");

        // R3 rejections leave chain and cursor alone
        do_start(32'h2002, 8, 4, 1'b1, "R3");
        do_start(32'h2000, 3, 4, 1'b1, "R3");
        do_start(32'h2000, 0, 4, 1'b1, "R3");
        do_start(32'h2000, 2048, 4, 1'b1, "R3");
        do_start(32'h2000, 8, 0, 1'b1, "R3");
        do_start(32'h2000, 8, 17, 1'b1, "R3");
        do_query(0, "R3");          // still at tail -> NULL
        check_desc(1, "R3");        // old chain intact

        // R9: start and query together
        @(negedge clk);
        start_valid = 1'b1; start_base = 32'h8000; start_eof_num = 12'd6; start_count = 5'd2;
        q_valid = 1'b1; eof_addr = 0;
        @(negedge clk);
        start_valid = 1'b0; q_valid = 1'b0;
        chk(resp_valid == 1'b0, "R9", "dropped query", int'(resp_valid), 0);
        m_cur = -1; m_built = 1; m_cnt = 2; m_base = 32'h8000; m_size = 12;
        do_query(0, "R9");          // cursor was reset: VALID 0
        check_desc(1, "R10");

        // full depth chain
        do_start(32'h1_0000, 2046, 16, 1'b0, "R3");
        check_desc(15, "R2");
        check_desc(0, "R10");
        for (int n = 0; n < 17; n++) do_query(slot(20), "R8");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R5", "missing responses", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule